// File: doc/BRIEF.md
# Packed SIMD Saturating Integer ALU

This block is a single-cycle packed-integer ALU for a 64-bit media datapath. Each operand word is read either as eight unsigned 8-bit lanes or as four signed 16-bit lanes. One opcode is applied to every lane at once. The opcodes cover saturating add and subtract, min, max, the four bitwise logicals, three per-lane shifts and three compares. The result word and an 8-bit lane condition vector come out of registers one cycle after the request.

The second operand can come from three places. It can be the matching lane of source B. It can be one lane of source B, chosen by an index, copied to every lane. Or it can be a 5-bit immediate copied to every lane. The surrounding pipeline supplies both sources and the control fields together with a valid strobe. It reads the result one cycle later under the output strobe.

Top module: `simd_sat_alu`

## Requirements
- R1: With `fmt_i`=0 (byte lanes, lane i at bits [8i+7:8i], unsigned), add (opcode 0) and subtract (opcode 1) give the exact lane result clamped to 0..255.
- R2: With `fmt_i`=1 (halfword lanes, lane i at bits [16i+15:16i], two's complement), add and subtract give the exact lane result clamped to -32768..32767.
- R3: Min (opcode 2) and max (opcode 3) pick per lane, comparing unsigned in byte format and signed in halfword format.
- R4: AND (4), OR (5), XOR (6) and NOR (7) act bitwise on each lane against the second operand.
- R5: Shift left logical (8), shift right logical (9) and shift right arithmetic (10) move each lane of A by the low 3 bits (byte) or low 4 bits (halfword) of the matching second-operand lane. Arithmetic right shift fills with the lane's top bit in both formats.
- R6: `mode_i`=0 uses lane i of B. `mode_i`=1 copies lane `idx_i` of B to all lanes; halfword format uses only `idx_i[1:0]`. `mode_i`=2 copies `imm_i` to all lanes, zero-extended for byte lanes and sign-extended for halfword lanes. `mode_i`=3 behaves as 0.
- R7: Compare equal (11), less-than (12) and less-or-equal (13) set flag bit i from lane i, with the same signedness as R3, and give a zero result word. Non-compare operations leave `flags_o` unchanged.
- R8: A halfword compare writes flags 0 to 3 and clears flags 4 to 7.
- R9: `valid_o` follows `valid_i` one cycle later. `result_o` and `flags_o` change only in the cycle after an accepted request.
- R10: While `rst_ni` is low, `valid_o`, `result_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| fmt_i | input | 1 | 0 = eight unsigned bytes, 1 = four signed halfwords |
| mode_i | input | 2 | Second-operand source: 0 vector, 1 indexed lane, 2 immediate |
| idx_i | input | 3 | Lane index for indexed mode |
| imm_i | input | 5 | Immediate for immediate mode |
| op_i | input | 4 | Opcode, values 0 to 13 per requirements |
| src_a_i | input | 64 | Source A |
| src_b_i | input | 64 | Source B |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Registered lane results |
| flags_o | output | 8 | Registered per-lane condition flags |

## Verification
Every opcode is run in both formats against pseudo-random vectors. These are mixed with words built near the lane limits, so clamped and unclamped sums can be told apart, and signed lane ordering can be told apart from unsigned ordering. Indexed mode is swept over all eight index values, with B lanes chosen to differ, so a wrong lane pick or a halfword index that fails to ignore bit 2 shows up in the result. All 32 immediates are run in both formats. This separates zero extension from sign extension, and it exercises shift amounts of 0 up to the lane width minus one. Compares alternate with non-compare operations so that flag retention and the clearing of the upper four flags are observed. Idle cycles with changed inputs confirm that the outputs hold.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MIN = 4'd2, OP_MAX = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_NOR = 4'd7,
    OP_SLL = 4'd8, OP_SRL = 4'd9, OP_SRA = 4'd10,
    OP_CEQ = 4'd11, OP_CLT = 4'd12, OP_CLE = 4'd13
  } simd_op_e;

  typedef enum logic [1:0] {
    MODE_VEC = 2'd0, MODE_SCL = 2'd1, MODE_IMM = 2'd2, MODE_RSV = 2'd3
  } opnd_mode_e;

  function automatic logic is_cmp(simd_op_e op);
    return (op == OP_CEQ) || (op == OP_CLT) || (op == OP_CLE);
  endfunction
endpackage

// File: rtl/simd_opnd_sel.sv
module simd_opnd_sel
  import simd_alu_pkg::*;
#(
  parameter int DW = 64,
  localparam int NB = DW / 8,
  localparam int NH = DW / 16,
  localparam int IW = $clog2(NB)
) (
  input  logic          fmt_i,
  input  opnd_mode_e    mode_i,
  input  logic [IW-1:0] idx_i,
  input  logic [4:0]    imm_i,
  input  logic [DW-1:0] src_b_i,
  output logic [DW-1:0] opnd_o
);
  logic [7:0]  b_byte [NB];
  logic [15:0] b_half [NH];

  for (genvar i = 0; i < NB; i++) begin : g_bsplit
    assign b_byte[i] = src_b_i[8*i +: 8];
  end
  for (genvar j = 0; j < NH; j++) begin : g_hsplit
    assign b_half[j] = src_b_i[16*j +: 16];
  end

  logic [7:0]  scl_b, imm_b;
  logic [15:0] scl_h, imm_h;

  assign scl_b = b_byte[idx_i];
  assign scl_h = b_half[idx_i[IW-2:0]];
  assign imm_b = {3'b000, imm_i};
  assign imm_h = {{11{imm_i[4]}}, imm_i};

  always_comb begin
    unique case (mode_i)
      MODE_SCL: opnd_o = fmt_i ? {NH{scl_h}} : {NB{scl_b}};
      MODE_IMM: opnd_o = fmt_i ? {NH{imm_h}} : {NB{imm_b}};
      default:  opnd_o = src_b_i;
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W   = 8,
  parameter bit SGN = 1'b0,
  localparam int SHW = $clog2(W),
  localparam int XW  = W + 2,
  localparam int HI_I = SGN ? (1 << (W - 1)) - 1 : (1 << W) - 1,
  localparam int LO_I = SGN ? -(1 << (W - 1)) : 0
) (
  input  simd_op_e       op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           cmp_o
);
  localparam logic signed [XW-1:0] HI = HI_I[XW-1:0];
  localparam logic signed [XW-1:0] LO = LO_I[XW-1:0];

  logic signed [XW-1:0] ax, bx, sum, dif;
  logic [W-1:0]         sum_s, dif_s, sra_v;
  logic [SHW-1:0]       sh;
  logic                 lt, eq;

  function automatic logic [W-1:0] clamp(logic signed [XW-1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  always_comb begin
    ax = SGN ? $signed({{2{a_i[W-1]}}, a_i}) : $signed({2'b00, a_i});
    bx = SGN ? $signed({{2{b_i[W-1]}}, b_i}) : $signed({2'b00, b_i});
    sum   = ax + bx;
    dif   = ax - bx;
    sum_s = clamp(sum);
    dif_s = clamp(dif);
    lt    = ax < bx;
    eq    = a_i == b_i;
    sh    = b_i[SHW-1:0];
    sra_v = $unsigned($signed(a_i) >>> sh);
  end

  always_comb begin
    res_o = '0;
    cmp_o = 1'b0;
    unique case (op_i)
      OP_ADD: res_o = sum_s;
      OP_SUB: res_o = dif_s;
      OP_MIN: res_o = lt ? a_i : b_i;
      OP_MAX: res_o = lt ? b_i : a_i;
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOR: res_o = ~(a_i | b_i);
      OP_SLL: res_o = a_i << sh;
      OP_SRL: res_o = a_i >> sh;
      OP_SRA: res_o = sra_v;
      OP_CEQ: cmp_o = eq;
      OP_CLT: cmp_o = lt;
      OP_CLE: cmp_o = lt | eq;
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DW = 64,
  localparam int NB = DW / 8,
  localparam int NH = DW / 16,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          fmt_i,
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] idx_i,
  input  logic [4:0]    imm_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o,
  output logic [NB-1:0] flags_o
);
  simd_op_e      op;
  logic [DW-1:0] opnd;
  logic [DW-1:0] res_b, res_h, res_d;
  logic [NB-1:0] cmp_b, flags_d;
  logic [NH-1:0] cmp_h;

  assign op = simd_op_e'(op_i);

  simd_opnd_sel #(.DW(DW)) u_opnd (
    .fmt_i   (fmt_i),
    .mode_i  (opnd_mode_e'(mode_i)),
    .idx_i   (idx_i),
    .imm_i   (imm_i),
    .src_b_i (src_b_i),
    .opnd_o  (opnd)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(8), .SGN(1'b0)) u_lane (
      .op_i  (op),
      .a_i   (src_a_i[8*i +: 8]),
      .b_i   (opnd[8*i +: 8]),
      .res_o (res_b[8*i +: 8]),
      .cmp_o (cmp_b[i])
    );
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    simd_lane #(.W(16), .SGN(1'b1)) u_lane (
      .op_i  (op),
      .a_i   (src_a_i[16*j +: 16]),
      .b_i   (opnd[16*j +: 16]),
      .res_o (res_h[16*j +: 16]),
      .cmp_o (cmp_h[j])
    );
  end

  assign res_d   = fmt_i ? res_h : res_b;
  assign flags_d = fmt_i ? {{(NB-NH){1'b0}}, cmp_h} : cmp_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        if (is_cmp(op)) flags_o <= flags_d;
      end
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DW = 64,
  localparam int NB = DW / 8,
  localparam int IW = $clog2(NB)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          fmt_i,
  input logic [1:0]    mode_i,
  input logic [IW-1:0] idx_i,
  input logic [4:0]    imm_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] src_a_i,
  input logic [DW-1:0] src_b_i,
  input logic          valid_o,
  input logic [DW-1:0] result_o,
  input logic [NB-1:0] flags_o
);
  logic cmp_req;
  logic [7:0] b_pick;
  assign cmp_req = (op_i == 4'd11) || (op_i == 4'd12) || (op_i == 4'd13);
  assign b_pick  = src_b_i[{idx_i, 3'b000} +: 8];

  a_r1_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && mode_i == 2'd0 && op_i == 4'd0)
    |=> result_o[7:0] >= $past(src_a_i[7:0]));

  a_r2_no_sign_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i && mode_i == 2'd0 && op_i == 4'd0 && !src_a_i[15] && !src_b_i[15])
    |=> !result_o[15]);

  a_r6_scalar_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && mode_i == 2'd1 && op_i == 4'd5 && src_a_i == '0)
    |=> result_o[7:0] == $past(b_pick));

  a_r6_imm_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && mode_i == 2'd2 && op_i == 4'd5 && src_a_i == '0)
    |=> result_o[7:0] == {3'b000, $past(imm_i)});

  a_r7_cmp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmp_req) |=> result_o == '0);

  a_r7_flags_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cmp_req) |=> $stable(flags_o));

  a_r8_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i && cmp_req) |=> flags_o[NB-1:NB/2] == '0);

  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r9_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(flags_o));

  always_comb begin
    if (!rst_ni) begin
      a_r10_reset_zero: assert (!valid_o && result_o == '0 && flags_o == '0);
    end
  end
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/simd_sat_alu_tb.sv
`timescale 1ns/1ps
module simd_sat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        fmt_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  idx_i = '0;
  logic [4:0]  imm_i = '0;
  logic [3:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [7:0]  flags_o;

  int total = 0, bad = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
  logic [7:0]  exp_flags = '0;
  logic [63:0] exp_res = '0;

  always #2 clk = ~clk;

  simd_sat_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fmt_i(fmt_i),
    .mode_i(mode_i), .idx_i(idx_i), .imm_i(imm_i), .op_i(op_i),
    .src_a_i(a_i), .src_b_i(b_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic [63:0] nxt(logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  function automatic string tag_of(int op, bit fmt);
    if (op <= 1) return fmt ? "R2" : "R1";
    if (op <= 3) return "R3";
    if (op <= 7) return "R4";
    if (op <= 10) return "R5";
    return "R7";
  endfunction

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference computed from the requirement text
  task automatic model(int op, bit fmt, int mode, int idx, int imm,
                       logic [63:0] a, logic [63:0] b);
    int w = fmt ? 16 : 8;
    int n = 64 / w;
    longint mask = (64'd1 << w) - 1;
    longint hi = fmt ? 32767 : 255;
    longint lo = fmt ? -32768 : 0;
    longint bsel;
    logic [63:0] r = '0;
    logic [7:0] f = '0;
    if (mode == 1) bsel = (b >> ((fmt ? (idx & 3) : idx) * w)) & mask;
    else bsel = fmt ? (((imm & 16) != 0 ? imm - 32 : imm) & mask) : imm;
    for (int i = 0; i < n; i++) begin
      longint ar = (a >> (i * w)) & mask;
      longint br = (mode == 1 || mode == 2) ? bsel : ((b >> (i * w)) & mask);
      longint as = ar >= (64'd1 << (w - 1)) ? ar - (64'd1 << w) : ar;
      longint bs = br >= (64'd1 << (w - 1)) ? br - (64'd1 << w) : br;
      longint av = fmt ? as : ar;
      longint bv = fmt ? bs : br;
      longint sh = br & (w - 1);
      longint v = 0;
      case (op)
        0: begin v = av + bv; if (v > hi) v = hi; if (v < lo) v = lo; end
        1: begin v = av - bv; if (v > hi) v = hi; if (v < lo) v = lo; end
        2: v = av < bv ? av : bv;
        3: v = av < bv ? bv : av;
        4: v = ar & br;
        5: v = ar | br;
        6: v = ar ^ br;
        7: v = ~(ar | br);
        8: v = ar << sh;
        9: v = ar >> sh;
        10: v = as >>> sh;
        11: f[i] = (ar == br);
        12: f[i] = (av < bv);
        13: f[i] = (av <= bv);
        default: ;
      endcase
      r |= 64'(v & mask) << (i * w);
    end
    exp_res = r;
    if (op >= 11) exp_flags = f;
  endtask

  task automatic run_op(int op, bit fmt, int mode, int idx, int imm,
                        logic [63:0] a, logic [63:0] b, string tag);
    op_i = 4'(op); fmt_i = fmt; mode_i = 2'(mode); idx_i = 3'(idx);
    imm_i = 5'(imm); a_i = a; b_i = b; valid_i = 1'b1;
    model(op, fmt, mode, idx, imm, a, b);
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0;
    chk64({tag, " R9 valid"}, {63'd0, valid_o}, 64'd1);
    chk64({tag, " result"}, result_o, exp_res);
    chk64({tag, " flags"}, {56'd0, flags_o}, {56'd0, exp_flags});
    if (fmt && op >= 11) chk64("R8 upper flags", {60'd0, flags_o[7:4]}, 64'd0);
  endtask

  task automatic idle_check();
    logic [63:0] r = result_o;
    logic [7:0]  f = flags_o;
    a_i = ~a_i; b_i = ~b_i; op_i = 4'd0; valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk64("R9 idle valid", {63'd0, valid_o}, 64'd0);
    chk64("R9 idle result", result_o, r);
    chk64("R9 idle flags", {56'd0, flags_o}, {56'd0, f});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ea, eb;
    repeat (3) @(negedge clk);
    // R10: outputs are zero in reset
    chk64("R10 valid", {63'd0, valid_o}, 64'd0);
    chk64("R10 result", result_o, 64'd0);
    chk64("R10 flags", {56'd0, flags_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed limit cases (R1, R2)
    run_op(0, 0, 0, 0, 0, 64'hFA00_80FF_0102_7F10, 64'h0A01_8001_FEFE_8010, "R1");
    run_op(1, 0, 0, 0, 0, 64'h0500_80FF_0102_7F10, 64'h0A01_8100_0203_7F20, "R1");
    run_op(0, 1, 0, 0, 0, 64'h7FF8_8000_0001_C000, 64'h0064_FFFF_7FFF_C000, "R2");
    run_op(1, 1, 0, 0, 0, 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_1234, "R2");
    idle_check();

    // vector mode sweep: every opcode, both formats, edge and random words
    for (int fm = 0; fm < 2; fm++)
      for (int op = 0; op < 14; op++)
        for (int k = 0; k < 40; k++) begin
          rng = nxt(rng); ea = rng;
          rng = nxt(rng); eb = rng;
          if (k % 4 == 1) begin ea |= 64'h7070_7070_7070_7070; eb |= 64'h7070_7070_7070_7070; end
          if (k % 4 == 2) begin ea &= 64'h8F8F_8F8F_8F8F_8F8F; eb = ea ^ (64'h0101_0000_0101_0000 << (k % 8)); end
          if (k % 4 == 3) eb = ea;
          run_op(op, bit'(fm), (k % 10 == 9) ? 3 : 0, 0, 0, ea, eb, tag_of(op, bit'(fm)));
          if (k == 7) idle_check();
        end

    // R6 indexed lane: every index, both formats
    for (int fm = 0; fm < 2; fm++)
      for (int ix = 0; ix < 8; ix++)
        for (int op = 0; op < 14; op++) begin
          rng = nxt(rng); ea = rng;
          run_op(op, bit'(fm), 1, ix, 0, ea, 64'h8877_F055_3311_7F02, "R6");
        end

    // R6 immediate: all 32 values, both formats
    for (int fm = 0; fm < 2; fm++)
      for (int im = 0; im < 32; im++)
        for (int op = 0; op < 14; op++) begin
          rng = nxt(rng); ea = rng;
          run_op(op, bit'(fm), 2, 0, im, ea, ~ea, "R6");
        end

    // R7 flags retained across a non-compare
    run_op(11, 0, 0, 0, 0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, "R7");
    run_op(4, 0, 0, 0, 0, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, "R7");
    // R8: byte compare sets upper flags, halfword compare clears them
    run_op(11, 0, 0, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, "R8");
    run_op(12, 1, 0, 0, 0, 64'h8000_0001_7FFF_FFFF, 64'h0000_0002_8000_0000, "R8");
    idle_check();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule